// File: doc/BRIEF.md
# Float32 Range Select Unit

This unit compares two IEEE-754 single-precision values and returns one of them: the smaller, the larger, the one with the smaller magnitude or the one with the larger magnitude. A separate control field then sets the sign of the returned value. The sign can follow the first operand or the chosen operand, or it can be forced positive or negative. With "smaller magnitude" and "sign of first operand", the unit clamps a value symmetrically into a band ±L, where L is the second operand.

NaN inputs, opposite-signed zeros and equal magnitudes with opposite signs follow fixed rules. Denormal inputs can be flushed to zero. The unit reports an invalid flag and a denormal flag. The 32-bit result is the low lane of a 128-bit destination, and the upper 96 bits pass through from the first source. A lane mask either merges the old destination value or zeroes it. An optional output register, on by default, adds one cycle of latency.

Top module: `fp32_range_select`

## Requirements
- R1: `ctrl_i[1:0]` selects the comparison. The encodings are 00 min, 01 max, 10 min of absolute value and 11 max of absolute value. With a ≤ b, min returns a and max returns b; otherwise min returns b and max returns a. The magnitude modes apply the same rule to |a| and |b|.
- R2: `ctrl_i[3:2]` sets result bit 31. The encodings are 00 sign of a, 01 sign of the chosen operand, 10 cleared and 11 set. Bits 30:0 always come from the chosen operand.
- R3: A signalling NaN has exponent 0xFF, fraction bit 22 clear and a nonzero fraction. If a is signalling, the result is a with bit 22 set. Otherwise, if b is signalling, the result is b with bit 22 set. In both cases `invalid_o` is raised and the sign control is ignored.
- R4: A quiet NaN has exponent 0xFF and bit 22 set. If b is a quiet NaN, the chosen value is a. Otherwise, if a is a quiet NaN, the chosen value is b. The sign control still applies.
- R5: A denormal has exponent 0 and a nonzero fraction. When `daz_i` is high, the fraction of a denormal operand is cleared before use. When `daz_i` is low, `denorm_o` is raised for a denormal operand unless the other operand is a quiet NaN. A signalling NaN on either input suppresses `denorm_o`.
- R6: When the operands are +0 and -0 in either order, min returns -0 and max returns +0. Both magnitude modes return a.
- R7: When the operands are nonzero, have equal magnitude and have opposite signs, min-abs returns the negative operand and max-abs returns the positive one.
- R8: `dst_o[127:32]` equals `src1_i[127:32]` in every case.
- R9: The lane is written when `mask_en_i` is low or `mask_bit_i` is high. If the lane is not written, `dst_o[31:0]` is either `dst_old_i` (when `zero_mask_i` is low) or zero (when `zero_mask_i` is high).
- R10: When the lane is not written, `invalid_o` and `denorm_o` stay low.
- R11: `ctrl_i[7:4]` has no effect on any output.
- R12: With `OUT_REG`=1, every output reflects the inputs of the previous clock edge. Every output is zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src1_i | input | 128 | First source; low 32 bits are operand a |
| src2_i | input | 32 | Operand b |
| dst_old_i | input | 32 | Previous destination low lane, used for merging |
| ctrl_i | input | 8 | Comparison select [1:0], sign select [3:2], [7:4] unused |
| daz_i | input | 1 | Flush denormal operands to zero |
| mask_en_i | input | 1 | Lane masking enabled |
| mask_bit_i | input | 1 | Mask bit for the low lane |
| zero_mask_i | input | 1 | 1 = zero an unwritten lane, 0 = merge |
| dst_o | output | 128 | Destination value |
| invalid_o | output | 1 | Invalid flag (signalling NaN seen) |
| denorm_o | output | 1 | Denormal operand flag |

## Verification
Two of the unit's functions can act on the same operation: the NaN priority and the sign override. A signalling NaN makes the sign control inert, while a quiet NaN leaves it active. The bench drives both NaN kinds with every sign encoding and checks bit 31 of the result against the rule for that NaN kind. The mask logic can also meet the flag logic in one cycle. Denormal and signalling-NaN operands are sent into masked lanes, and the bench expects both flags to stay low while the merge or zero value appears.

// File: rtl/fp32_range_select.sv
module fp32_range_select #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [127:0] src1_i,
  input  logic [31:0]  src2_i,
  input  logic [31:0]  dst_old_i,
  input  logic [7:0]   ctrl_i,
  input  logic         daz_i,
  input  logic         mask_en_i,
  input  logic         mask_bit_i,
  input  logic         zero_mask_i,
  output logic [127:0] dst_o,
  output logic         invalid_o,
  output logic         denorm_o
);
  localparam int QBIT = 22;

  logic [31:0] a_raw, b_raw, a, b, pick, signed_pick, res, lo;
  logic a_snan, b_snan, a_qnan, b_qnan, a_den, b_den;
  logic le, abs_le, zero_opp, mag_opp, we, inv_c, den_c;

  assign a_raw = src1_i[31:0];
  assign b_raw = src2_i;

  assign a_qnan = (&a_raw[30:23]) && a_raw[QBIT];
  assign b_qnan = (&b_raw[30:23]) && b_raw[QBIT];
  assign a_snan = (&a_raw[30:23]) && !a_raw[QBIT] && (|a_raw[21:0]);
  assign b_snan = (&b_raw[30:23]) && !b_raw[QBIT] && (|b_raw[21:0]);
  assign a_den  = (a_raw[30:23] == 8'd0) && (|a_raw[22:0]);
  assign b_den  = (b_raw[30:23] == 8'd0) && (|b_raw[22:0]);

  assign a = (daz_i && a_den) ? {a_raw[31:23], 23'd0} : a_raw;
  assign b = (daz_i && b_den) ? {b_raw[31:23], 23'd0} : b_raw;

  assign abs_le   = a[30:0] <= b[30:0];
  assign le       = (a[31] != b[31]) ? a[31] : (a[31] ? (a[30:0] >= b[30:0]) : abs_le);
  assign zero_opp = (a[30:0] == 31'd0) && (b[30:0] == 31'd0) && (a[31] != b[31]);
  assign mag_opp  = (a[30:0] == b[30:0]) && (a[31] != b[31]) && ctrl_i[1];

  always_comb begin
    if (b_qnan)        pick = a;
    else if (a_qnan)   pick = b;
    else if (zero_opp) begin
      case (ctrl_i[1:0])
        2'b00:   pick = 32'h8000_0000;
        2'b01:   pick = 32'h0000_0000;
        default: pick = a;
      endcase
    end else if (mag_opp) begin
      pick = (ctrl_i[0] ^ a[31]) ? a : b;
    end else begin
      case (ctrl_i[1:0])
        2'b00:   pick = le ? a : b;
        2'b01:   pick = le ? b : a;
        2'b10:   pick = abs_le ? a : b;
        default: pick = abs_le ? b : a;
      endcase
    end
  end

  always_comb begin
    case (ctrl_i[3:2])
      2'b00:   signed_pick = {a[31], pick[30:0]};
      2'b01:   signed_pick = pick;
      2'b10:   signed_pick = {1'b0, pick[30:0]};
      default: signed_pick = {1'b1, pick[30:0]};
    endcase
  end

  assign res   = a_snan ? (a_raw | (32'd1 << QBIT)) :
                 b_snan ? (b_raw | (32'd1 << QBIT)) : signed_pick;
  assign inv_c = a_snan || b_snan;
  assign den_c = !inv_c && !daz_i && ((a_den && !b_qnan) || (b_den && !a_qnan));
  assign we    = !mask_en_i || mask_bit_i;
  assign lo    = we ? res : (zero_mask_i ? 32'd0 : dst_old_i);

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dst_o     <= '0;
          invalid_o <= 1'b0;
          denorm_o  <= 1'b0;
        end else begin
          dst_o     <= {src1_i[127:32], lo};
          invalid_o <= inv_c && we;
          denorm_o  <= den_c && we;
        end
      end

      assert_upper_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> dst_o[127:32] == $past(src1_i[127:32]));
      assert_merge_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_en_i && !mask_bit_i && !zero_mask_i) |=> dst_o[31:0] == $past(dst_old_i));
      assert_zero_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_en_i && !mask_bit_i && zero_mask_i) |=> dst_o[31:0] == 32'd0);
      assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_en_i && !mask_bit_i) |=> !invalid_o && !denorm_o);
      assert_snan_quieted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> (&dst_o[30:22]) && !denorm_o);
      assert_force_neg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !a_snan && !b_snan && ctrl_i[3:2] == 2'b11) |=> dst_o[31]);
    end else begin : g_comb
      assign dst_o     = {src1_i[127:32], lo};
      assign invalid_o = inv_c && we;
      assign denorm_o  = den_c && we;
    end
  endgenerate
endmodule

// File: tb/fp32_range_select_test.sv
module fp32_range_select_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [127:0] src1;
  logic [31:0] src2, old;
  logic [7:0] ctrl;
  logic daz, men, mbit, zm;
  logic [127:0] dst;
  logic inv, den;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fp32_range_select uut (
    .clk(clk), .rst_n(rst_n), .src1_i(src1), .src2_i(src2), .dst_old_i(old),
    .ctrl_i(ctrl), .daz_i(daz), .mask_en_i(men), .mask_bit_i(mbit), .zero_mask_i(zm),
    .dst_o(dst), .invalid_o(inv), .denorm_o(den));

  function automatic bit is_nan(logic [31:0] x); return x[30:23] == 8'hFF && x[22:0] != 0; endfunction
  function automatic bit is_q(logic [31:0] x);   return is_nan(x) && x[22]; endfunction
  function automatic bit is_s(logic [31:0] x);   return is_nan(x) && !x[22]; endfunction
  function automatic bit is_d(logic [31:0] x);   return x[30:23] == 0 && x[22:0] != 0; endfunction

  // true when x <= y as real numbers (non-NaN inputs)
  function automatic bit fle(logic [31:0] x, logic [31:0] y);
    if (x[30:0] == 0 && y[30:0] == 0) return 1;
    if (x[31] && !y[31]) return 1;
    if (!x[31] && y[31]) return 0;
    if (!x[31]) return x[30:0] <= y[30:0];
    return y[30:0] <= x[30:0];
  endfunction

  function automatic logic [129:0] model(logic [31:0] ra, logic [31:0] rb, logic [31:0] od,
                                         logic [7:0] c, bit dz, bit me, bit mb, bit z);
    logic [31:0] x, y, t, r;
    bit iv, dn, wr;
    x = (dz && is_d(ra)) ? {ra[31], 31'd0} & 32'hFF80_0000 | {ra[31], 31'd0} : ra;
    y = (dz && is_d(rb)) ? {rb[31], 31'd0} : rb;
    iv = is_s(ra) || is_s(rb);
    dn = !iv && !dz && ((is_d(ra) && !is_q(rb)) || (is_d(rb) && !is_q(ra)));
    if (is_s(ra)) r = {ra[31:23], 1'b1, ra[21:0]};
    else if (is_s(rb)) r = {rb[31:23], 1'b1, rb[21:0]};
    else begin
      if (is_q(y)) t = x;
      else if (is_q(x)) t = y;
      else if (x[30:0] == 0 && y[30:0] == 0 && x[31] != y[31])
        t = (c[1:0] == 0) ? 32'h8000_0000 : (c[1:0] == 1) ? 32'h0 : x;
      else if (c[1] && x[30:0] == y[30:0] && x[31] != y[31])
        t = (c[0] == x[31]) ? y : x;
      else case (c[1:0])
        0: t = fle(x, y) ? x : y;
        1: t = fle(x, y) ? y : x;
        2: t = (x[30:0] <= y[30:0]) ? x : y;
        default: t = (x[30:0] <= y[30:0]) ? y : x;
      endcase
      case (c[3:2])
        0: r = {x[31], t[30:0]};
        1: r = t;
        2: r = {1'b0, t[30:0]};
        default: r = {1'b1, t[30:0]};
      endcase
    end
    wr = !me || mb;
    if (!wr) begin r = z ? 32'd0 : od; iv = 0; dn = 0; end
    return {r, iv, dn} | 130'd0;
  endfunction

  task automatic check(string tag);
    logic [129:0] e;
    logic [127:0] ed;
    e = model(src1[31:0], src2, old, ctrl, daz, men, mbit, zm);
    ed = {src1[127:32], e[33:2]};
    checks++;
    if (dst !== ed || inv !== e[1] || den !== e[0]) begin
      fails++;
      $display("FAIL %s: got dst=%h inv=%b den=%b exp dst=%h inv=%b den=%b",
               tag, dst, inv, den, ed, e[1], e[0]);
    end
  endtask

  task automatic apply(logic [31:0] a, logic [31:0] b, logic [7:0] c, bit dz,
                       bit me, bit mb, bit z, string tag);
    @(negedge clk);
    src1 = {$urandom, $urandom, $urandom, a};
    src2 = b; ctrl = c; daz = dz; men = me; mbit = mb; zm = z; old = $urandom;
    @(posedge clk); #1;
    check(tag);
  endtask

  function automatic logic [31:0] rnd_val(logic [31:0] other);
    int k = $urandom_range(0, 11);
    logic [31:0] r = $urandom;
    case (k)
      0: return {r[31], 31'd0};
      1: return {r[31], 8'hFF, 23'd0};
      2: return {r[31], 8'hFF, 1'b1, r[21:0]};
      3: return {r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
      4: return {r[31], 8'd0, r[22:1], 1'b1};
      5: return {~other[31], other[30:0]};
      6: return other;
      default: return r;
    endcase
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang exp finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] va, vb;
    void'($urandom(32'd1234));
    src1 = '1; src2 = '1; old = '1; ctrl = 8'hFF; daz = 0; men = 0; mbit = 0; zm = 0;
    repeat (3) @(posedge clk);
    #1; checks++;
    if (dst !== 0 || inv !== 0 || den !== 0) begin
      fails++; $display("FAIL R12 reset: got %h %b %b exp 0 0 0", dst, inv, den);
    end
    @(negedge clk); rst_n = 1;

    // R1 symmetric clamp: -200 limited by 150 -> -150, +100 kept
    apply(32'hC348_0000, 32'h4316_0000, 8'h02, 0, 0, 0, 0, "R1 clamp");
    checks++;
    if (dst[31:0] !== 32'hC316_0000) begin fails++; $display("FAIL R1 clamp: got %h exp c3160000", dst[31:0]); end
    apply(32'h42C8_0000, 32'h4316_0000, 8'h02, 0, 0, 0, 0, "R1 clamp in band");
    apply(32'h3F80_0000, 32'hBF80_0000, 8'h01, 0, 0, 0, 0, "R1 max");
    // R2 every sign code on a normal pair
    for (int s = 0; s < 4; s++) apply(32'hC000_0000, 32'h3F80_0000, {4'h0, s[1:0], 2'b00}, 0, 0, 0, 0, "R2 sign");
    // R3 sNaN priority, sign control inert
    apply(32'h7F80_0001, 32'hFF80_0002, 8'h0C, 0, 0, 0, 0, "R3 snan a");
    checks++;
    if (dst[31:0] !== 32'h7FC0_0001 || !inv) begin fails++; $display("FAIL R3: got %h %b exp 7fc00001 1", dst[31:0], inv); end
    apply(32'h3F80_0000, 32'hFF80_0002, 8'h08, 0, 0, 0, 0, "R3 snan b");
    // R4 qNaN handling, both-qNaN picks a
    apply(32'h7FC0_0005, 32'hFFC0_0007, 8'h04, 0, 0, 0, 0, "R4 both qnan");
    apply(32'hFFC0_0000, 32'h4000_0000, 8'h00, 0, 0, 0, 0, "R4 qnan a sign a");
    // R5 denormals with and without flush
    apply(32'h0000_0001, 32'h8000_0000, 8'h00, 1, 0, 0, 0, "R5 daz");
    apply(32'h0000_0001, 32'h3F80_0000, 8'h00, 0, 0, 0, 0, "R5 denorm flag");
    apply(32'h0000_0001, 32'h7FC0_0000, 8'h00, 0, 0, 0, 0, "R5 qnan suppresses");
    apply(32'h0000_0001, 32'h7F80_0001, 8'h00, 0, 0, 0, 0, "R5 snan suppresses");
    // R6 opposite zeros, R7 equal magnitude
    for (int m = 0; m < 4; m++) apply(32'h0000_0000, 32'h8000_0000, {6'd1, m[1:0]}, 0, 0, 0, 0, "R6 zeros");
    for (int m = 0; m < 4; m++) apply(32'h8000_0000, 32'h0000_0000, {6'd1, m[1:0]}, 0, 0, 0, 0, "R6 zeros swapped");
    apply(32'h4040_0000, 32'hC040_0000, 8'h06, 0, 0, 0, 0, "R7 minabs");
    apply(32'hC040_0000, 32'h4040_0000, 8'h07, 0, 0, 0, 0, "R7 maxabs");
    // R9 R10 masking with flag-raising operands
    apply(32'h7F80_0001, 32'h0000_0003, 8'h00, 0, 1, 0, 0, "R10 merge snan");
    apply(32'h0000_0003, 32'h3F80_0000, 8'h00, 0, 1, 0, 1, "R10 zero denorm");
    apply(32'h3F80_0000, 32'h4000_0000, 8'h01, 0, 1, 1, 1, "R9 mask set");
    // R11 upper control bits ignored
    apply(32'hC348_0000, 32'h4316_0000, 8'hF2, 0, 0, 0, 0, "R11 ctrl high");
    checks++;
    if (dst[31:0] !== 32'hC316_0000) begin fails++; $display("FAIL R11: got %h exp c3160000", dst[31:0]); end

    for (int i = 0; i < 4000; i++) begin
      va = $urandom;
      vb = rnd_val(va);
      va = rnd_val(vb);
      apply(va, vb, 8'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0),
            1'($urandom), 1'($urandom), "R1/R2/R3/R4/R5/R8/R9 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule